// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Periodic Refresh

This block sits between a processor-side request port and an asynchronous DRAM whose cells are arranged as a square array of rows and columns. It takes one read or write request at a time. It splits the request address into a row field and a column field and places them one after the other on a shared set of address pins. It lowers the row strobe, then the column strobe, and drives or samples the data nibble. It then raises both strobes and waits for precharge before it takes the next job.

The stored charge leaks, so every row has to be reopened at a steady rate. An internal timer counts a programmable number of clock cycles and then marks a refresh as due. At the next idle decision the refresh goes ahead of any waiting request. It is performed as a row-strobe-only cycle on the address held in an internal row counter. A processor request that arrives in the meantime is simply held until the refresh and its precharge are over. With default parameters the array is 2048 x 2048 nibbles, which is 16 Mbit, behind a 22-bit request address and 11 address pins.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While rstN is low, dramRasN, dramCasN, dramWeN and dramOeN are all high and reqAck is low.
- R2: An access lowers dramRasN with the row field reqAddr[ROW_W+COL_W-1:COL_W] on dramAddr and keeps it low for one full cycle before dramCasN falls.
- R3: dramCasN falls only while dramRasN is already low, and at that moment dramAddr carries the column field reqAddr[COL_W-1:0].
- R4: For a write (reqWrite = 1) dramWeN is low and dramOeN is high while dramCasN is low, and dramDqOut carries reqWdata, so the nibble is stored at the addressed cell. dramWeN and dramOeN are never low together.
- R5: For a read (reqWrite = 0) dramOeN is low and dramWeN is high while dramCasN is low, and rdData holds the addressed cell's nibble in the cycle reqAck is high.
- R6: After every access or refresh both strobes return high for a precharge cycle and an idle cycle, so dramRasN stays high for at least two cycles between any two low periods.
- R7: reqAck is a single-cycle pulse. It is seen 4 cycles after a request is presented to an idle controller, and never more than 8 cycles after, even when a refresh cuts in first.
- R8: A refresh becomes due every REFRESH_PERIOD cycles. A due refresh is started at the next idle decision ahead of a waiting request, so consecutive refresh starts are exactly REFRESH_PERIOD apart under no traffic and within 4 cycles of it under traffic.
- R9: A refresh holds dramRasN low for exactly 2 cycles with dramCasN high throughout. It drives the refresh row counter on dramAddr, which starts at 0 after reset and steps by one per refresh, wrapping modulo 2^ROW_W.
- R10: No request is served during a refresh. reqAck stays low and dramCasN stays high while the refresh row strobe is low, and the held request completes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present, held until reqAck |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ROW_W+COL_W | Cell address, row field above column field |
| reqWdata | input | DATA_W | Write nibble |
| reqAck | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Read nibble, valid with reqAck |
| dramAddr | output | max(ROW_W,COL_W) | Multiplexed row/column address pins |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramDqOut | output | DATA_W | Data driven to the DRAM |
| dramDqIn | input | DATA_W | Data returned by the DRAM |

## Verification
The bench builds the controller with ROW_W = 3, COL_W = 3, DATA_W = 4 and REFRESH_PERIOD = 37. This shrinks the array to 64 cells, so every cell can be written and read back twice with arithmetic patterns against a behavioural DRAM that latches row and column on the strobe edges. The short refresh period makes refreshes cut into accesses at many different phases, and the row counter wraps several times during a run. A quiet stretch with no requests lets the exact refresh spacing be measured.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_DATA,
    ST_PRE,
    ST_RFA,
    ST_RFB
  } ctrlState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic accept;   // latch request fields
    logic rasOn;    // row strobe active
    logic casOn;    // column strobe active
    logic selCol;   // address mux: column field
    logic selRef;   // address mux: refresh row
    logic capture;  // end of data phase: ack and read sample
    logic refStep;  // advance refresh row counter
  } ctrlStrobes_t;

endpackage

// File: rtl/dramc_ctrl.sv
module dramc_ctrl
  import dramc_pkg::*;
#(
  parameter int REFRESH_PERIOD = 1560
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output ctrlStrobes_t strobes
);

  localparam int TMR_W = $clog2(REFRESH_PERIOD + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(REFRESH_PERIOD - 1);

  ctrlState_t state, stateNext;
  logic [TMR_W-1:0] refTimer;
  logic refPending;
  logic takeRefresh;

  assign takeRefresh = (state == ST_IDLE) && refPending;

  // refresh interval timer and pending flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refTimer   <= '0;
      refPending <= 1'b0;
    end else begin
      if (refTimer == TMR_LAST) begin
        refTimer   <= '0;
        refPending <= 1'b1;
      end else begin
        refTimer <= refTimer + 1'b1;
        if (takeRefresh) refPending <= 1'b0;
      end
    end
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (refPending)    stateNext = ST_RFA;
        else if (reqValid) stateNext = ST_ROW;
      end
      ST_ROW:  stateNext = ST_COL;
      ST_COL:  stateNext = ST_DATA;
      ST_DATA: stateNext = ST_PRE;
      ST_RFA:  stateNext = ST_RFB;
      ST_RFB:  stateNext = ST_PRE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes         = '0;
    strobes.accept  = (state == ST_IDLE) && !refPending && reqValid;
    strobes.rasOn   = (state == ST_ROW) || (state == ST_COL) || (state == ST_DATA) ||
                      (state == ST_RFA) || (state == ST_RFB);
    strobes.casOn   = (state == ST_COL) || (state == ST_DATA);
    strobes.selCol  = strobes.casOn;
    strobes.selRef  = (state == ST_RFA) || (state == ST_RFB);
    strobes.capture = (state == ST_DATA);
    strobes.refStep = (state == ST_RFB);
  end

endmodule

// File: rtl/dramc_dpath.sv
module dramc_dpath
  import dramc_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 4,
  parameter int PIN_W  = 11
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  input  logic                   reqWrite,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic                   reqAck,
  output logic [DATA_W-1:0]      rdData,
  output logic [PIN_W-1:0]       dramAddr,
  output logic                   dramRasN,
  output logic                   dramCasN,
  output logic                   dramWeN,
  output logic                   dramOeN,
  output logic [DATA_W-1:0]      dramDqOut,
  input  logic [DATA_W-1:0]      dramDqIn
);

  logic [ROW_W-1:0]  rowReg;
  logic [COL_W-1:0]  colReg;
  logic [DATA_W-1:0] dataReg;
  logic              writeReg;
  logic [ROW_W-1:0]  refRow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg   <= '0;
      colReg   <= '0;
      dataReg  <= '0;
      writeReg <= 1'b0;
      refRow   <= '0;
      reqAck   <= 1'b0;
      rdData   <= '0;
    end else begin
      if (strobes.accept) begin
        rowReg   <= reqAddr[ROW_W+COL_W-1:COL_W];
        colReg   <= reqAddr[COL_W-1:0];
        dataReg  <= reqWdata;
        writeReg <= reqWrite;
      end
      if (strobes.refStep) refRow <= refRow + 1'b1;
      reqAck <= strobes.capture;
      if (strobes.capture && !writeReg) rdData <= dramDqIn;
    end
  end

  always_comb begin
    if (strobes.selRef)      dramAddr = PIN_W'(refRow);
    else if (strobes.selCol) dramAddr = PIN_W'(colReg);
    else                     dramAddr = PIN_W'(rowReg);
  end

  assign dramRasN  = !strobes.rasOn;
  assign dramCasN  = !strobes.casOn;
  assign dramWeN   = !(strobes.casOn && writeReg);
  assign dramOeN   = !(strobes.casOn && !writeReg);
  assign dramDqOut = dataReg;

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dramc_pkg::*;
#(
  parameter int ROW_W          = 11,
  parameter int COL_W          = 11,
  parameter int DATA_W         = 4,
  parameter int REFRESH_PERIOD = 1560,
  localparam int ADDR_W        = ROW_W + COL_W,
  localparam int PIN_W         = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqAck,
  output logic [DATA_W-1:0] rdData,
  output logic [PIN_W-1:0]  dramAddr,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              dramWeN,
  output logic              dramOeN,
  output logic [DATA_W-1:0] dramDqOut,
  input  logic [DATA_W-1:0] dramDqIn
);

  ctrlStrobes_t strobes;

  dramc_ctrl #(
    .REFRESH_PERIOD(REFRESH_PERIOD)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .strobes (strobes)
  );

  dramc_dpath #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .DATA_W(DATA_W),
    .PIN_W (PIN_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqAck   (reqAck),
    .rdData   (rdData),
    .dramAddr (dramAddr),
    .dramRasN (dramRasN),
    .dramCasN (dramCasN),
    .dramWeN  (dramWeN),
    .dramOeN  (dramOeN),
    .dramDqOut(dramDqOut),
    .dramDqIn (dramDqIn)
  );

endmodule

// File: rtl/dramc_checker.sv
module dramc_checker #(
  parameter int ROW_W = 11,
  parameter int COL_W = 11,
  parameter int PIN_W = 11
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ROW_W+COL_W-1:0] reqAddr,
  input logic                   reqAck,
  input logic [PIN_W-1:0]       dramAddr,
  input logic                   dramRasN,
  input logic                   dramCasN,
  input logic                   dramWeN,
  input logic                   dramOeN
);

  AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (!rstN)
    !dramCasN |-> !dramRasN);  // R3
  AST_RAS_LEADS_CAS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramCasN) |-> $past(!dramRasN));  // R2
  AST_COL_ON_PINS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramCasN) |-> dramAddr == PIN_W'(reqAddr[COL_W-1:0]));  // R3
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!dramWeN && !dramOeN));  // R4
  AST_WE_IN_CAS: assert property (@(posedge clk) disable iff (!rstN)
    (!dramWeN || !dramOeN) |-> !dramCasN);  // R4
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dramRasN) |=> dramRasN);  // R6
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);  // R7
  AST_ACK_AFTER_CAS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqAck) |-> $past(!dramCasN));  // R7

endmodule

bind dram_refresh_ctrl dramc_checker #(
  .ROW_W(ROW_W),
  .COL_W(COL_W),
  .PIN_W(PIN_W)
) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .reqAddr (reqAddr),
  .reqAck  (reqAck),
  .dramAddr(dramAddr),
  .dramRasN(dramRasN),
  .dramCasN(dramCasN),
  .dramWeN (dramWeN),
  .dramOeN (dramOeN)
);

// File: tb/dram_refresh_ctrl_bench.sv
`timescale 1ns/1ps
module dram_refresh_ctrl_bench;

  localparam int ROW_W  = 3;
  localparam int COL_W  = 3;
  localparam int DATA_W = 4;
  localparam int PERIOD = 37;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int CELLS  = 1 << ADDR_W;
  localparam int PIN_W  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic reqAck;
  logic [DATA_W-1:0] rdData;
  logic [PIN_W-1:0] dramAddr;
  logic dramRasN, dramCasN, dramWeN, dramOeN;
  logic [DATA_W-1:0] dramDqOut, dramDqIn;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dram_refresh_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .REFRESH_PERIOD(PERIOD)
  ) u_dram_refresh_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqAck(reqAck), .rdData(rdData),
    .dramAddr(dramAddr), .dramRasN(dramRasN), .dramCasN(dramCasN),
    .dramWeN(dramWeN), .dramOeN(dramOeN), .dramDqOut(dramDqOut),
    .dramDqIn(dramDqIn)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  // behavioural DRAM, evaluated between clock edges
  logic [DATA_W-1:0] mem [CELLS];
  logic [ROW_W-1:0] rowL = '0;
  logic [COL_W-1:0] colL = '0;
  logic rasPrev = 1'b1, casPrev = 1'b1;

  assign dramDqIn = (!dramCasN && !dramOeN) ? mem[{rowL, colL}] : '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!dramRasN && rasPrev) rowL <= dramAddr[ROW_W-1:0];
      if (!dramCasN && casPrev) begin
        colL <= dramAddr[COL_W-1:0];
        check(!dramRasN, "R3 cas fall with ras low", int'(dramRasN), 0);
      end else if (!dramCasN && !dramWeN) begin
        mem[{rowL, colL}] <= dramDqOut;
      end
    end
    rasPrev <= dramRasN;
    casPrev <= dramCasN;
  end

  // refresh and precharge monitor
  int cyc = 0;
  int lowLen = 0, highLen = 0, lastRefStart = -1, refCount = 0, startCyc = 0;
  bit sawCas = 0, ackInLow = 0, firstLow = 1, quietMeasure = 0, prevQuiet = 0, curQuiet = 0;
  logic [PIN_W-1:0] lowRow = '0;
  logic [ROW_W-1:0] expRef = '0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (!dramRasN) begin
        if (rasPrev) begin
          if (!firstLow) check(highLen >= 2, "R6 ras high gap", highLen, 2);
          firstLow = 0;
          lowRow = dramAddr; sawCas = 0; ackInLow = 0; lowLen = 0;
          startCyc = cyc; curQuiet = quietMeasure;
        end
        lowLen++;
        if (!dramCasN) sawCas = 1;
        if (reqAck) ackInLow = 1;
        highLen = 0;
      end else begin
        highLen++;
        if (!rasPrev && !sawCas) begin
          refCount++;
          check(lowRow == PIN_W'(expRef), "R9 refresh row", int'(lowRow), int'(expRef));
          check(lowLen == 2, "R9 refresh ras length", lowLen, 2);
          check(!ackInLow, "R10 no ack during refresh", int'(ackInLow), 0);
          if (lastRefStart >= 0) begin
            if (curQuiet && prevQuiet)
              check(startCyc - lastRefStart == PERIOD, "R8 quiet spacing",
                    startCyc - lastRefStart, PERIOD);
            else
              check((startCyc - lastRefStart >= PERIOD - 4) && (startCyc - lastRefStart <= PERIOD + 4),
                    "R8 busy spacing", startCyc - lastRefStart, PERIOD);
          end
          lastRefStart = startCyc;
          prevQuiet = curQuiet;
          expRef = expRef + 1'b1;
        end
      end
    end
  end

  // watchdog
  initial begin
    #(5 * 150000);
    check(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [DATA_W-1:0] model [CELLS];

  task automatic access(input bit wr, input int addr, input logic [DATA_W-1:0] wd);
    int lat;
    reqValid = 1'b1; reqWrite = wr; reqAddr = ADDR_W'(addr); reqWdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!reqAck && lat < 40);
    check(lat >= 4 && lat <= 8, "R7 ack latency", lat, 4);
    if (!wr) check(rdData == model[addr], "R5 read data", int'(rdData), int'(model[addr]));
    else model[addr] = wd;
    reqValid = 1'b0;
    @(negedge clk);
    check(!reqAck, "R7 ack single pulse", int'(reqAck), 0);
  endtask

  initial begin
    for (int i = 0; i < CELLS; i++) begin mem[i] = '0; model[i] = '0; end
    repeat (4) @(negedge clk);
    check(dramRasN && dramCasN && dramWeN && dramOeN, "R1 strobes high in reset",
          int'({dramRasN, dramCasN, dramWeN, dramOeN}), 15);
    check(!reqAck, "R1 ack low in reset", int'(reqAck), 0);
    rstN = 1'b1;
    @(negedge clk);
    // first: idle latency exactly 4 (R7) with R2/R4 sequencing
    begin
      int lat;
      reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 6'o52; reqWdata = 4'hA;
      @(negedge clk); lat = 1;
      check(!dramRasN && dramCasN && dramAddr == 3'o5, "R2 row on pins", int'(dramAddr), 5);
      @(negedge clk); lat++;
      check(!dramCasN && !dramWeN && dramOeN && dramAddr == 3'o2 && dramDqOut == 4'hA,
            "R4 write column phase", int'(dramAddr), 2);
      while (!reqAck && lat < 40) begin @(negedge clk); lat++; end
      check(lat == 4, "R7 idle ack latency", lat, 4);
      model[6'o52] = 4'hA;
      reqValid = 1'b0;
      @(negedge clk);
    end
    // sweep: write all cells, read all, second pattern
    for (int a = 0; a < CELLS; a++) access(1'b1, a, DATA_W'(a * 5 + 3));
    for (int a = 0; a < CELLS; a++) access(1'b0, a, '0);
    for (int a = CELLS - 1; a >= 0; a--) access(1'b1, a, DATA_W'(~(a * 3 + a / 8)));
    for (int a = 0; a < CELLS; a++) access(1'b0, a, '0);
    // read phase check for R5 strobe polarity
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 6'o17;
    while (dramCasN) @(negedge clk);
    check(!dramOeN && dramWeN, "R5 read strobes", int'({dramOeN, dramWeN}), 1);
    while (!reqAck) @(negedge clk);
    check(rdData == model[6'o17], "R5 read data", int'(rdData), int'(model[6'o17]));
    reqValid = 1'b0;
    @(negedge clk);
    // quiet stretch for exact refresh spacing
    repeat (2 * PERIOD) @(negedge clk);
    quietMeasure = 1;
    repeat (5 * PERIOD) @(negedge clk);
    quietMeasure = 0;
    check(refCount >= cyc / (PERIOD + 4) - 2, "R8 refresh count", refCount, cyc / (PERIOD + 4));
    check(expRef != '0 || refCount >= 8, "R9 row counter advanced", refCount, 8);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule